// File: doc/BRIEF.md
# UART Sleep and Low-Power Controller

This block decides, cycle by cycle, whether a UART core and its baud-rate generator may have their clocks stopped. It runs on an always-on reference clock. It watches the transmit and receive FIFO flags, the interrupt-pending flag, the receive line and the modem status inputs. When sleep is enabled and the UART has been quiet for long enough, it drops a clock-enable that an external gating cell uses.

Any start bit on the receive line, any write into the transmit FIFO, or any change on a modem input restores the clock-enable. Once the UART is quiet again, the block goes back to sleep without help, and it keeps doing so until sleep is disabled. A separate low-power pin overrides all of this. While the pin is high, the clock-enable is held off and the host-side pins are isolated. Divisor-latch writes that arrive during sleep are reported on an error output.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `core_clk_en`=1, `sleep_flag`=0, `host_iso`=0 and `div_err`=0.
- R2: Sleep is entered only while both `enh_en` and `sleep_en` are 1. If either one is 0, `sleep_flag` stays 0.
- R3: Sleep is entered only when all of these hold: `tx_fifo_empty`=1, `tx_shift_empty`=1, `rx_fifo_empty`=1, `irq_pend`=0, and the modem inputs are unchanged. While asleep with `lowpwr_pin` low, `core_clk_en` is the inverse of `sleep_flag`.
- R4: When `rx_ovr`=0, entry also needs the synchronised RX line to have been high for 4 × (1 + data bits + parity bit + stop bits) baud ticks. Data bits are 5 + `data_bits` (00=5 … 11=8), the parity bit is counted when `parity_en`=1, and there are 2 stop bits when `stop2`=1, otherwise 1. Any low level on RX clears the count.
- R5: When `rx_ovr`=1, the RX line level is ignored for entry.
- R6: While asleep, any of these wakes the block: a falling edge on `rx_in`, a `tx_fifo_wr` pulse, or a change on any bit of `modem_in`. A `tx_fifo_wr` pulse restores `core_clk_en` at the first clock edge. An edge on `modem_in` restores it at the third clock edge, after two synchroniser stages and the edge detector.
- R7: After a wake, the block re-enters sleep by itself as soon as the entry conditions hold again.
- R8: Clearing `sleep_en` while asleep restores `core_clk_en`=1 and clears `sleep_flag` at the next clock edge.
- R9: `lowpwr_pin`=1 forces `core_clk_en`=0 and `host_iso`=1 at the next clock edge, whatever the sleep state or the wake events. When the pin returns low, `host_iso` clears at the next edge and `core_clk_en` follows the sleep state.
- R10: A `div_wr` pulse sampled while `sleep_flag`=1 raises `div_err` for exactly the next cycle. While awake, `div_wr` leaves `div_err` at 0.
- R11: If a wake event arrives in the same cycle in which the entry conditions first become true, the block stays awake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst | input | 1 | Synchronous active-high reset |
| enh_en | input | 1 | Enhanced-functions enable |
| sleep_en | input | 1 | Sleep enable |
| rx_ovr | input | 1 | Ignore the RX idle condition for entry |
| rx_in | input | 1 | Serial receive line (asynchronous) |
| modem_in | input | MODEM_W | Modem status inputs (asynchronous) |
| tx_fifo_empty | input | 1 | Transmit FIFO empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| rx_fifo_empty | input | 1 | Receive FIFO empty |
| irq_pend | input | 1 | An interrupt is pending |
| tx_fifo_wr | input | 1 | Write strobe into the transmit FIFO |
| baud_tick | input | 1 | One pulse per bit time |
| data_bits | input | 2 | Data length code, 00=5 … 11=8 bits |
| parity_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| div_wr | input | 1 | Divisor-latch write strobe |
| lowpwr_pin | input | 1 | Forced low-power request |
| core_clk_en | output | 1 | Clock-enable for the UART core and baud generator |
| sleep_flag | output | 1 | Sleep-mode state |
| host_iso | output | 1 | Host-pin isolation enable |
| div_err | output | 1 | A divisor write was attempted during sleep |

## Verification
There are two places where this block's functions can fall in the same cycle. The first is the entry decision meeting a wake event. The bench holds the block awake with a pending interrupt, then in one cycle it removes the interrupt and pulses a transmit-FIFO write. The block must stay awake that cycle and must fall asleep only in the next one. The second is the low-power pin meeting a wake event. The bench raises the pin while the UART is asleep and writes into the transmit FIFO during it. The clock-enable must stay off throughout, and isolation must hold until the pin is released.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;

  typedef enum logic {
    PM_AWAKE  = 1'b0,
    PM_ASLEEP = 1'b1
  } pm_state_t;

  localparam int unsigned IDLE_CHARS = 4;

  // Bits in one character frame: start + data + parity + stop.
  function automatic logic [3:0] frame_bits(input logic [1:0] dlen,
                                            input logic       par,
                                            input logic       two_stop);
    frame_bits = 4'd1 + (4'd5 + {2'b00, dlen}) + {3'b000, par} +
                 (two_stop ? 4'd2 : 4'd1);
  endfunction

endpackage

// File: rtl/uart_sleep_sync.sv
module uart_sleep_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage[i] <= {W{RST_VAL}};
        else if (i == 0) stage[i] <= d;
        else stage[i] <= stage[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/uart_sleep_idle.sv
module uart_sleep_idle #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_high,
  input  logic             baud_tick,
  input  logic [CNT_W-1:0] limit,
  output logic             idle_ok
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !rx_high) cnt <= '0;
    else if (baud_tick && (cnt < limit)) cnt <= cnt + 1'b1;
  end

  assign idle_ok = (cnt >= limit);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uart_sleep_pkg::*;
#(
  parameter int MODEM_W     = 4,
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enh_en,
  input  logic               sleep_en,
  input  logic               rx_ovr,
  input  logic               rx_in,
  input  logic [MODEM_W-1:0] modem_in,
  input  logic               tx_fifo_empty,
  input  logic               tx_shift_empty,
  input  logic               rx_fifo_empty,
  input  logic               irq_pend,
  input  logic               tx_fifo_wr,
  input  logic               baud_tick,
  input  logic [1:0]         data_bits,
  input  logic               parity_en,
  input  logic               stop2,
  input  logic               div_wr,
  input  logic               lowpwr_pin,
  output logic               core_clk_en,
  output logic               sleep_flag,
  output logic               host_iso,
  output logic               div_err
);
  localparam int SHIFT = $clog2(IDLE_CHARS);

  logic               rx_s, rx_q;
  logic [MODEM_W-1:0] mdm_s, mdm_q;
  logic               idle_ok;
  logic [CNT_W-1:0]   idle_limit;
  logic               allow, quiet, wake, rx_fall, mdm_chg;
  pm_state_t          state, state_nx;

  uart_sleep_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_rx_sync (
    .clk(clk), .rst(rst), .d(rx_in), .q(rx_s)
  );

  uart_sleep_sync #(.W(MODEM_W), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_mdm_sync (
    .clk(clk), .rst(rst), .d(modem_in), .q(mdm_s)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q  <= 1'b1;
      mdm_q <= '0;
    end else begin
      rx_q  <= rx_s;
      mdm_q <= mdm_s;
    end
  end

  assign rx_fall = rx_q & ~rx_s;
  assign mdm_chg = |(mdm_q ^ mdm_s);

  assign idle_limit = CNT_W'(frame_bits(data_bits, parity_en, stop2)) << SHIFT;

  uart_sleep_idle #(.CNT_W(CNT_W)) u_idle (
    .clk(clk), .rst(rst), .rx_high(rx_s), .baud_tick(baud_tick),
    .limit(idle_limit), .idle_ok(idle_ok)
  );

  assign allow = enh_en & sleep_en;
  assign wake  = rx_fall | tx_fifo_wr | mdm_chg;
  assign quiet = tx_fifo_empty & tx_shift_empty & rx_fifo_empty & ~irq_pend &
                 (rx_ovr | idle_ok) & ~wake;

  always_comb begin
    state_nx = state;
    if (!allow)                     state_nx = PM_AWAKE;
    else if (state == PM_ASLEEP)    state_nx = wake ? PM_AWAKE : PM_ASLEEP;
    else if (quiet)                 state_nx = PM_ASLEEP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PM_AWAKE;
      core_clk_en <= 1'b1;
      sleep_flag  <= 1'b0;
      host_iso    <= 1'b0;
      div_err     <= 1'b0;
    end else begin
      state       <= state_nx;
      core_clk_en <= (state_nx == PM_AWAKE) & ~lowpwr_pin;
      sleep_flag  <= (state_nx == PM_ASLEEP);
      host_iso    <= lowpwr_pin;
      div_err     <= div_wr & (state == PM_ASLEEP);
    end
  end
endmodule

// File: rtl/uart_sleep_ctrl_chk.sv
module uart_sleep_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic enh_en,
  input logic sleep_en,
  input logic tx_fifo_empty,
  input logic tx_shift_empty,
  input logic rx_fifo_empty,
  input logic irq_pend,
  input logic tx_fifo_wr,
  input logic div_wr,
  input logic lowpwr_pin,
  input logic core_clk_en,
  input logic sleep_flag,
  input logic host_iso,
  input logic div_err
);
  AST_RST_STATE: assert property (@(posedge clk)
    rst |=> (core_clk_en && !sleep_flag && !host_iso && !div_err)); // R1

  AST_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    (!enh_en || !sleep_en) |=> !sleep_flag); // R2

  AST_ENTRY_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!sleep_flag ##1 sleep_flag) |->
      $past(tx_fifo_empty && tx_shift_empty && rx_fifo_empty && !irq_pend)); // R3

  AST_CLKEN_TRACKS: assert property (@(posedge clk) disable iff (rst)
    !host_iso |-> (core_clk_en == !sleep_flag)); // R3

  AST_TXWR_WAKE: assert property (@(posedge clk) disable iff (rst)
    (sleep_flag && tx_fifo_wr && !lowpwr_pin) |=> (core_clk_en && !sleep_flag)); // R6

  AST_LOWPWR_FORCE: assert property (@(posedge clk) disable iff (rst)
    lowpwr_pin |=> (host_iso && !core_clk_en)); // R9

  AST_DIVERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (!div_wr || !sleep_flag) |=> !div_err); // R10
endmodule

bind uart_sleep_ctrl uart_sleep_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .enh_en(enh_en), .sleep_en(sleep_en),
  .tx_fifo_empty(tx_fifo_empty), .tx_shift_empty(tx_shift_empty),
  .rx_fifo_empty(rx_fifo_empty), .irq_pend(irq_pend), .tx_fifo_wr(tx_fifo_wr),
  .div_wr(div_wr), .lowpwr_pin(lowpwr_pin), .core_clk_en(core_clk_en),
  .sleep_flag(sleep_flag), .host_iso(host_iso), .div_err(div_err)
);

// File: tb/tb_uart_sleep_ctrl.sv
`timescale 1ns/1ps
module tb_uart_sleep_ctrl;
  localparam int MODEM_W = 4;

  logic clk = 1'b0;
  logic rst, enh_en, sleep_en, rx_ovr, rx_in;
  logic [MODEM_W-1:0] modem_in;
  logic tx_fifo_empty, tx_shift_empty, rx_fifo_empty, irq_pend, tx_fifo_wr;
  logic baud_tick, parity_en, stop2, div_wr, lowpwr_pin;
  logic [1:0] data_bits;
  logic core_clk_en, sleep_flag, host_iso, div_err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  uart_sleep_ctrl #(.MODEM_W(MODEM_W)) dut (
    .clk(clk), .rst(rst), .enh_en(enh_en), .sleep_en(sleep_en), .rx_ovr(rx_ovr),
    .rx_in(rx_in), .modem_in(modem_in), .tx_fifo_empty(tx_fifo_empty),
    .tx_shift_empty(tx_shift_empty), .rx_fifo_empty(rx_fifo_empty),
    .irq_pend(irq_pend), .tx_fifo_wr(tx_fifo_wr), .baud_tick(baud_tick),
    .data_bits(data_bits), .parity_en(parity_en), .stop2(stop2), .div_wr(div_wr),
    .lowpwr_pin(lowpwr_pin), .core_clk_en(core_clk_en), .sleep_flag(sleep_flag),
    .host_iso(host_iso), .div_err(div_err)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d cycles expected=finished", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic cyc_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    baud_tick = 1'b1;
    cyc_n(n);
    baud_tick = 1'b0;
  endtask

  task automatic defaults();
    enh_en = 1; sleep_en = 1; rx_ovr = 0; rx_in = 1; modem_in = '0;
    tx_fifo_empty = 1; tx_shift_empty = 1; rx_fifo_empty = 1; irq_pend = 0;
    tx_fifo_wr = 0; baud_tick = 0; data_bits = 2'b11; parity_en = 0; stop2 = 0;
    div_wr = 0; lowpwr_pin = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    defaults();
    rst = 1;
    cyc_n(2);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic sleep_via_ovr();
    rx_ovr = 1;
    cyc_n(3);
  endtask

  task automatic t_reset();
    @(negedge clk);
    defaults();
    rst = 1;
    cyc_n(2);
    chk("R1 clk_en in reset", core_clk_en, 1'b1);
    chk("R1 sleep in reset", sleep_flag, 1'b0);
    rst = 0;
    @(negedge clk);
    chk("R1 clk_en after reset", core_clk_en, 1'b1);
    chk("R1 sleep_flag after reset", sleep_flag, 1'b0);
    chk("R1 host_iso after reset", host_iso, 1'b0);
    chk("R1 div_err after reset", div_err, 1'b0);
  endtask

  task automatic t_enable();
    do_reset();
    enh_en = 0; rx_ovr = 1;
    cyc_n(5);
    chk("R2 enh_en=0 blocks sleep", sleep_flag, 1'b0);
    enh_en = 1; sleep_en = 0;
    cyc_n(5);
    chk("R2 sleep_en=0 blocks sleep", sleep_flag, 1'b0);
    sleep_en = 1;
    cyc_n(3);
    chk("R2 both enabled sleeps", sleep_flag, 1'b1);
    chk("R3 clk_en off while asleep", core_clk_en, 1'b0);
  endtask

  task automatic t_entry_block(input int which);
    do_reset();
    rx_ovr = 1;
    case (which)
      0: tx_fifo_empty = 0;
      1: tx_shift_empty = 0;
      2: rx_fifo_empty = 0;
      default: irq_pend = 1;
    endcase
    cyc_n(6);
    chk($sformatf("R3 blocker %0d prevents sleep", which), sleep_flag, 1'b0);
    chk($sformatf("R3 blocker %0d keeps clk_en", which), core_clk_en, 1'b1);
    defaults(); rx_ovr = 1;
    cyc_n(3);
    chk($sformatf("R3 blocker %0d removed sleeps", which), sleep_flag, 1'b1);
  endtask

  task automatic t_idle(input logic [1:0] dl, input logic par, input logic s2, input int limit);
    do_reset();
    data_bits = dl; parity_en = par; stop2 = s2;
    cyc_n(6);
    chk("R4 no ticks no sleep", sleep_flag, 1'b0);
    ticks(limit - 2);
    cyc_n(3);
    chk($sformatf("R4 below limit %0d", limit), sleep_flag, 1'b0);
    rx_in = 0;
    cyc_n(4);
    rx_in = 1;
    cyc_n(4);
    ticks(4);
    cyc_n(3);
    chk("R4 low RX clears idle count", sleep_flag, 1'b0);
    ticks(limit);
    cyc_n(3);
    chk($sformatf("R4 reached limit %0d", limit), sleep_flag, 1'b1);
  endtask

  task automatic t_override();
    do_reset();
    rx_in = 0;
    cyc_n(4);
    rx_ovr = 1;
    cyc_n(3);
    chk("R5 override sleeps with RX low", sleep_flag, 1'b1);
  endtask

  task automatic t_wake();
    do_reset();
    sleep_via_ovr();
    tx_fifo_wr = 1;
    @(negedge clk);
    tx_fifo_wr = 0;
    chk("R6 tx write restores clk_en", core_clk_en, 1'b1);
    @(negedge clk);
    chk("R7 re-sleeps after tx write", sleep_flag, 1'b1);
    modem_in = 4'b0100;
    @(posedge clk); @(posedge clk); @(posedge clk);
    @(negedge clk);
    chk("R6 modem change wakes on third edge", core_clk_en, 1'b1);
    @(negedge clk);
    chk("R7 re-sleeps after modem change", sleep_flag, 1'b1);
    rx_ovr = 0;
    cyc_n(2);
    rx_in = 0;
    cyc_n(4);
    chk("R6 RX start bit wakes", core_clk_en, 1'b1);
    cyc_n(10);
    chk("R4 stays awake with RX low", sleep_flag, 1'b0);
    rx_in = 1;
    cyc_n(4);
    ticks(45);
    cyc_n(3);
    chk("R7 re-sleeps after RX idle", sleep_flag, 1'b1);
  endtask

  task automatic t_disable();
    do_reset();
    sleep_via_ovr();
    sleep_en = 0;
    @(negedge clk);
    chk("R8 clk_en next cycle", core_clk_en, 1'b1);
    chk("R8 sleep_flag cleared", sleep_flag, 1'b0);
    cyc_n(4);
    chk("R8 stays awake", sleep_flag, 1'b0);
  endtask

  task automatic t_lowpwr();
    do_reset();
    irq_pend = 1;
    cyc_n(2);
    lowpwr_pin = 1;
    @(negedge clk);
    chk("R9 clk_en off when awake", core_clk_en, 1'b0);
    chk("R9 host_iso on", host_iso, 1'b1);
    lowpwr_pin = 0;
    @(negedge clk);
    chk("R9 release restores clk_en", core_clk_en, 1'b1);
    chk("R9 release clears iso", host_iso, 1'b0);
    irq_pend = 0;
    sleep_via_ovr();
    lowpwr_pin = 1;
    @(negedge clk);
    tx_fifo_wr = 1;
    @(negedge clk);
    tx_fifo_wr = 0;
    chk("R9 wake under low-power keeps clk off", core_clk_en, 1'b0);
    chk("R9 iso held during wake", host_iso, 1'b1);
    cyc_n(2);
    lowpwr_pin = 0;
    @(negedge clk);
    chk("R9 release while asleep keeps clk off", core_clk_en, 1'b0);
    chk("R9 release while asleep clears iso", host_iso, 1'b0);
  endtask

  task automatic t_diverr();
    do_reset();
    irq_pend = 1;
    cyc_n(2);
    div_wr = 1;
    @(negedge clk);
    div_wr = 0;
    chk("R10 awake write no error", div_err, 1'b0);
    irq_pend = 0;
    sleep_via_ovr();
    div_wr = 1;
    @(negedge clk);
    div_wr = 0;
    chk("R10 sleep write flags error", div_err, 1'b1);
    @(negedge clk);
    chk("R10 error lasts one cycle", div_err, 1'b0);
  endtask

  task automatic t_simul();
    do_reset();
    rx_ovr = 1; irq_pend = 1;
    cyc_n(3);
    irq_pend = 0; tx_fifo_wr = 1;
    @(negedge clk);
    tx_fifo_wr = 0;
    chk("R11 wake in entry cycle stays awake", sleep_flag, 1'b0);
    chk("R11 clk_en held", core_clk_en, 1'b1);
    @(negedge clk);
    chk("R11 sleeps one cycle later", sleep_flag, 1'b1);
  endtask

  initial begin
    defaults();
    rst = 1;
    t_reset();
    t_enable();
    for (int b = 0; b < 4; b++) t_entry_block(b);
    t_idle(2'b11, 1'b0, 1'b0, 40);
    t_idle(2'b00, 1'b0, 1'b0, 28);
    t_idle(2'b11, 1'b1, 1'b1, 48);
    t_override();
    t_wake();
    t_disable();
    t_lowpwr();
    t_diverr();
    t_simul();
    summary();
  end
endmodule